// File: doc/BRIEF.md
# Write-Leveling Pass Sequencer

This block drives one write-leveling training pass for a single selected memory module on the controller side of a DDR3 interface. A start pulse latches the target module, its module kind, a pass selector and optional per-lane seed overrides. The block then takes the controller out of refresh and ZQ short calibration, asks a companion mode-register block to put the target ranks into leveling mode, and waits out the DRAM settling time. After that it enables the leveling ODT and hands a seed delay to each byte lane. It then holds the PHY training enable for a fixed window.

When the window closes, the sequencer reads each lane's measured phase one lane per cycle. It corrects a wrapped result and stores the value as that lane's write-DQS delay. It then drops the ODT and asks the companion block to return the ranks to normal operation. Finally it restores the refresh and ZQ settings and pulses done. Every delay byte carries a 3-bit gross field in bits [7:5] and a 5-bit fine field in bits [4:0]. A total of 0x1F equals one UI, which is half a clock.

Top module: `wl_train_seq`

## Requirements
- R1: While rst_ni is low and after its release, the block is idle. All write-DQS delays are 0, refresh suppression is off, the ZQ interval field reads 2, and all request, enable, load and done outputs are low.
- R2: From the cycle after an accepted start, dis_refresh_o is 1 and zq_ival_o is 0. Both stay so until the exit request completes. In the done cycle and afterwards they return to 0 and 2.
- R3: Right after an accepted start, mrs_req_o is high with mrs_entry_o=1. It stays high until mrs_done_i is sampled high. mrs_cs_o equals the latched module index shifted left by one, with bit 0 clear.
- R4: After the entry request completes, the block waits MR_SETTLE_CYC (40) cycles with the ODT off before it enables leveling ODT.
- R5: wl_odt_en_o is high for ODT_SETTLE_CYC (10) cycles before a one-cycle seed_load_o pulse. seed_o carries the lane seeds, with lane i in bits [8i+7:8i]. The ODT stays high through training and capture.
- R6: The default seed follows mod_kind_i as latched at start: 1 (registered) gives 0x41, 2 (small-outline) gives 0x12, and 0 or 3 (unbuffered) give 0x1A. A set bit i of seed_ovr_vld_i replaces lane i's default with byte i of seed_ovr_i.
- R7: train_en_o is high for TRAIN_FIRST_CYC (200) consecutive cycles right after the seed load. It is high for TRAIN_SECOND_CYC (32) cycles when second_pass_i was 1 at start.
- R8: In the LANES cycles after training ends, the block captures lane k from phase_res_i bits [8k+7:8k] in the k-th cycle. The stored value shows on wdqs_dly_o lane k from the next cycle. Lanes not yet captured keep their previous value.
- R9: When the lane's seed has gross field 0 and the captured result has gross field 3, the stored delay is 0x00. In all other cases it is the captured result unchanged.
- R10: After the last lane, the ODT is low for ODT_SETTLE_CYC (10) cycles. Then mrs_req_o rises with mrs_entry_o=0 and holds until mrs_done_i is sampled high.
- R11: done_o is high for exactly one cycle, the cycle after the exit request completes. busy_o is low in the cycle after that.
- R12: A start pulse while busy_o is high has no effect: the module index, kind, pass and overrides in use stay the ones latched at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| mod_sel_i | input | MOD_W | Target module index |
| mod_kind_i | input | 2 | Module kind: 0/3 unbuffered, 1 registered, 2 small-outline |
| second_pass_i | input | 1 | Selects the short training window |
| seed_ovr_vld_i | input | LANES | Per-lane override valid |
| seed_ovr_i | input | 8*LANES | Per-lane override seeds |
| phase_res_i | input | 8*LANES | Per-lane measured phase from the PHY |
| mrs_done_i | input | 1 | Companion mode-register sequence finished |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dis_refresh_o | output | 1 | Suppress auto-refresh |
| zq_ival_o | output | 2 | ZQ short-calibration interval field |
| mrs_req_o | output | 1 | Mode-register sequence request |
| mrs_entry_o | output | 1 | 1 = enter leveling, 0 = return to normal |
| mrs_cs_o | output | MOD_W+1 | Target chip select |
| wl_odt_en_o | output | 1 | Leveling ODT enable |
| seed_load_o | output | 1 | Seed load strobe |
| seed_o | output | 8*LANES | Lane seeds |
| train_en_o | output | 1 | PHY training enable |
| wdqs_dly_o | output | 8*LANES | Stored write-DQS delays |

## Verification
The bench uses the default parameters: eight lanes, a 2-bit module index and the full 40/10/200/32-cycle windows. Chip selects up to 6 and the wrap correction on every lane position can therefore be reached. Runs cover all three default seeds and mixed overrides on both window lengths. Lane results are chosen to hit gross 3 against seed gross 0, gross 3 against non-zero seed gross, and gross 0 against seed gross 0. A start pulse is also placed in the middle of a pass.

// File: rtl/wl_seq_pkg.sv
package wl_seq_pkg;
  localparam int DLY_W     = 8;
  localparam int GROSS_LSB = 5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_MR_ENTER, ST_MR_SETTLE, ST_ODT_ON, ST_SEED,
    ST_TRAIN, ST_CAPT, ST_ODT_OFF, ST_MR_EXIT, ST_FINISH
  } wl_state_e;

  function automatic logic [DLY_W-GROSS_LSB-1:0] gross_of(input logic [DLY_W-1:0] d);
    return d[DLY_W-1:GROSS_LSB];
  endfunction
endpackage

// File: rtl/wl_timer.sv
module wl_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/wl_seed_sel.sv
module wl_seed_sel
  import wl_seq_pkg::*;
#(
  parameter int              LANES     = 8,
  parameter logic [DLY_W-1:0] SEED_REG = 8'h41,
  parameter logic [DLY_W-1:0] SEED_SO  = 8'h12,
  parameter logic [DLY_W-1:0] SEED_UNB = 8'h1A
) (
  input  logic [1:0]             kind_i,
  input  logic [LANES-1:0]       ovr_vld_i,
  input  logic [DLY_W*LANES-1:0] ovr_i,
  output logic [DLY_W*LANES-1:0] seed_o
);
  logic [DLY_W-1:0] dflt;

  always_comb begin
    unique case (kind_i)
      2'd1:    dflt = SEED_REG;
      2'd2:    dflt = SEED_SO;
      default: dflt = SEED_UNB;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign seed_o[i*DLY_W +: DLY_W] = ovr_vld_i[i] ? ovr_i[i*DLY_W +: DLY_W] : dflt;
  end
endmodule

// File: rtl/wl_lane_store.sv
module wl_lane_store
  import wl_seq_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [LANE_W-1:0]      idx_i,
  input  logic [DLY_W*LANES-1:0] seed_i,
  input  logic [DLY_W*LANES-1:0] res_i,
  output logic [DLY_W*LANES-1:0] dly_o
);
  logic [DLY_W-1:0] sel_seed, sel_res, fixed;
  logic [LANES-1:0] lane_we;

  // one shared correction unit, lanes visited in turn
  assign sel_seed = seed_i[idx_i*DLY_W +: DLY_W];
  assign sel_res  = res_i[idx_i*DLY_W +: DLY_W];
  assign fixed    = (gross_of(sel_seed) == '0 && gross_of(sel_res) == 3'd3) ? '0 : sel_res;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = we_i && (idx_i == LANE_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         dly_o[i*DLY_W +: DLY_W] <= '0;
      else if (lane_we[i]) dly_o[i*DLY_W +: DLY_W] <= fixed;
    end
  end

  // R8
  lane_we_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lane_we));

  // R9
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_seed[7:5] == 3'd0 && sel_res[7:5] == 3'd3)
      |=> dly_o[$past(idx_i)*DLY_W +: DLY_W] == '0);
endmodule

// File: rtl/wl_train_seq.sv
module wl_train_seq
  import wl_seq_pkg::*;
#(
  parameter int LANES            = 8,
  parameter int MOD_W            = 2,
  parameter int MR_SETTLE_CYC    = 40,
  parameter int ODT_SETTLE_CYC   = 10,
  parameter int TRAIN_FIRST_CYC  = 200,
  parameter int TRAIN_SECOND_CYC = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [MOD_W-1:0]       mod_sel_i,
  input  logic [1:0]             mod_kind_i,
  input  logic                   second_pass_i,
  input  logic [LANES-1:0]       seed_ovr_vld_i,
  input  logic [8*LANES-1:0]     seed_ovr_i,
  input  logic [8*LANES-1:0]     phase_res_i,
  input  logic                   mrs_done_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   dis_refresh_o,
  output logic [1:0]             zq_ival_o,
  output logic                   mrs_req_o,
  output logic                   mrs_entry_o,
  output logic [MOD_W:0]         mrs_cs_o,
  output logic                   wl_odt_en_o,
  output logic                   seed_load_o,
  output logic [8*LANES-1:0]     seed_o,
  output logic                   train_en_o,
  output logic [8*LANES-1:0]     wdqs_dly_o
);
  localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int MAX_A   = (MR_SETTLE_CYC > ODT_SETTLE_CYC) ? MR_SETTLE_CYC : ODT_SETTLE_CYC;
  localparam int MAX_B   = (TRAIN_FIRST_CYC > TRAIN_SECOND_CYC) ? TRAIN_FIRST_CYC : TRAIN_SECOND_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam logic [1:0] ZQ_NORMAL = 2'd2;

  wl_state_e           st_q, st_d;
  logic [MOD_W-1:0]    mod_q;
  logic [1:0]          kind_q;
  logic                pass2_q;
  logic [LANES-1:0]    ovr_vld_q;
  logic [8*LANES-1:0]  ovr_q;
  logic [LANE_W-1:0]   lane_q;
  logic                t_load, t_exp;
  logic [TW-1:0]       t_val;

  always_comb begin
    st_d   = st_q;
    t_load = 1'b0;
    t_val  = '0;
    unique case (st_q)
      ST_IDLE:      if (start_i) st_d = ST_MR_ENTER;
      ST_MR_ENTER:  if (mrs_done_i) begin
                      st_d = ST_MR_SETTLE; t_load = 1'b1; t_val = TW'(MR_SETTLE_CYC - 1);
                    end
      ST_MR_SETTLE: if (t_exp) begin
                      st_d = ST_ODT_ON; t_load = 1'b1; t_val = TW'(ODT_SETTLE_CYC - 1);
                    end
      ST_ODT_ON:    if (t_exp) st_d = ST_SEED;
      ST_SEED:      begin
                      st_d = ST_TRAIN; t_load = 1'b1;
                      t_val = pass2_q ? TW'(TRAIN_SECOND_CYC - 1) : TW'(TRAIN_FIRST_CYC - 1);
                    end
      ST_TRAIN:     if (t_exp) st_d = ST_CAPT;
      ST_CAPT:      if (lane_q == LANE_W'(LANES - 1)) begin
                      st_d = ST_ODT_OFF; t_load = 1'b1; t_val = TW'(ODT_SETTLE_CYC - 1);
                    end
      ST_ODT_OFF:   if (t_exp) st_d = ST_MR_EXIT;
      ST_MR_EXIT:   if (mrs_done_i) st_d = ST_FINISH;
      ST_FINISH:    st_d = ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      mod_q     <= '0;
      kind_q    <= '0;
      pass2_q   <= 1'b0;
      ovr_vld_q <= '0;
      ovr_q     <= '0;
      lane_q    <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start_i) begin
        mod_q     <= mod_sel_i;
        kind_q    <= mod_kind_i;
        pass2_q   <= second_pass_i;
        ovr_vld_q <= seed_ovr_vld_i;
        ovr_q     <= seed_ovr_i;
      end
      if (st_q == ST_CAPT)
        lane_q <= (lane_q == LANE_W'(LANES - 1)) ? '0 : lane_q + 1'b1;
    end
  end

  wl_timer #(.TW(TW)) u_timer (
    .clk_i, .rst_ni, .load_i(t_load), .load_val_i(t_val), .expired_o(t_exp)
  );

  wl_seed_sel #(.LANES(LANES)) u_seed (
    .kind_i(kind_q), .ovr_vld_i(ovr_vld_q), .ovr_i(ovr_q), .seed_o(seed_o)
  );

  wl_lane_store #(.LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk_i, .rst_ni, .we_i(st_q == ST_CAPT), .idx_i(lane_q),
    .seed_i(seed_o), .res_i(phase_res_i), .dly_o(wdqs_dly_o)
  );

  assign busy_o        = (st_q != ST_IDLE);
  assign done_o        = (st_q == ST_FINISH);
  assign dis_refresh_o = busy_o && !done_o;
  assign zq_ival_o     = dis_refresh_o ? 2'd0 : ZQ_NORMAL;
  assign mrs_req_o     = (st_q == ST_MR_ENTER) || (st_q == ST_MR_EXIT);
  assign mrs_entry_o   = (st_q == ST_MR_ENTER);
  assign mrs_cs_o      = {mod_q, 1'b0};
  assign wl_odt_en_o   = (st_q == ST_ODT_ON) || (st_q == ST_SEED) ||
                         (st_q == ST_TRAIN)  || (st_q == ST_CAPT);
  assign seed_load_o   = (st_q == ST_SEED);
  assign train_en_o    = (st_q == ST_TRAIN);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  // R7
  train_odt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_en_o |-> wl_odt_en_o && !mrs_req_o);

  // R2
  mrs_refresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs_req_o |-> dis_refresh_o && zq_ival_o == 2'd0);

  // R12
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(mrs_cs_o));
endmodule

// File: tb/wl_train_seq_bench.sv
module wl_train_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int MOD_W = 2;
  localparam int MRS_LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, pass2 = 0, mrs_done = 0;
  logic [MOD_W-1:0] mod_sel = '0;
  logic [1:0] kind = '0;
  logic [LANES-1:0] ovr_vld = '0;
  logic [8*LANES-1:0] ovr = '0, res = '0;
  logic busy, done, dis_ref, mrs_req, mrs_entry, odt, sload, train;
  logic [1:0] zq;
  logic [MOD_W:0] cs;
  logic [8*LANES-1:0] seed, dly;

  int checks = 0, errors = 0, cyc = 0, resp_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wl_train_seq u_wl_train_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mod_sel_i(mod_sel),
    .mod_kind_i(kind), .second_pass_i(pass2), .seed_ovr_vld_i(ovr_vld),
    .seed_ovr_i(ovr), .phase_res_i(res), .mrs_done_i(mrs_done),
    .busy_o(busy), .done_o(done), .dis_refresh_o(dis_ref), .zq_ival_o(zq),
    .mrs_req_o(mrs_req), .mrs_entry_o(mrs_entry), .mrs_cs_o(cs),
    .wl_odt_en_o(odt), .seed_load_o(sload), .seed_o(seed),
    .train_en_o(train), .wdqs_dly_o(dly)
  );

  // reference model: phase 0 idle,1 enter,2 settle,3 odt on,4 seed,5 train,6 capture,7 odt off,8 exit,9 done
  int ph = 0, cnt = 0, m_mod = 0, m_kind = 0, m_pass2 = 0;
  logic [LANES-1:0] m_vld;
  logic [8*LANES-1:0] m_ovr;
  logic [7:0] m_dly[LANES];

  function automatic logic [7:0] ref_seed(int k, logic v, logic [7:0] o);
    if (v) return o;
    if (k == 1) return 8'h41;
    if (k == 2) return 8'h12;
    return 8'h1A;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; cnt = 0; m_mod = 0; m_kind = 0; m_pass2 = 0; m_vld = '0; m_ovr = '0;
      foreach (m_dly[i]) m_dly[i] = 8'h00;
    end else begin
      case (ph)
        0: if (start) begin
             ph = 1; m_mod = int'(mod_sel); m_kind = int'(kind); m_pass2 = int'(pass2);
             m_vld = ovr_vld; m_ovr = ovr;
           end
        1: if (mrs_done) begin ph = 2; cnt = 0; end
        2: begin cnt++; if (cnt == 40) begin ph = 3; cnt = 0; end end
        3: begin cnt++; if (cnt == 10) begin ph = 4; cnt = 0; end end
        4: begin ph = 5; cnt = 0; end
        5: begin cnt++; if (cnt == (m_pass2 ? 32 : 200)) begin ph = 6; cnt = 0; end end
        6: begin
             logic [7:0] s, r;
             s = ref_seed(m_kind, m_vld[cnt], m_ovr[cnt*8 +: 8]);
             r = res[cnt*8 +: 8];
             m_dly[cnt] = (s[7:5] == 3'd0 && r[7:5] == 3'd3) ? 8'h00 : r;
             cnt++;
             if (cnt == LANES) begin ph = 7; cnt = 0; end
           end
        7: begin cnt++; if (cnt == 10) begin ph = 8; cnt = 0; end end
        8: if (mrs_done) ph = 9;
        default: ph = 0;
      endcase
    end
  end

  task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    logic [8*LANES-1:0] exp_dly, exp_seed;
    logic m_dis;
    cyc++;
    m_dis = (ph >= 1 && ph <= 8);
    for (int i = 0; i < LANES; i++) begin
      exp_dly[i*8 +: 8]  = m_dly[i];
      exp_seed[i*8 +: 8] = ref_seed(m_kind, m_vld[i], m_ovr[i*8 +: 8]);
    end
    cmp("R1 R11 busy", 64'(busy), 64'(ph != 0));
    cmp("R11 done", 64'(done), 64'(ph == 9));
    cmp("R2 dis_refresh", 64'(dis_ref), 64'(m_dis));
    cmp("R2 zq_ival", 64'(zq), m_dis ? 64'd0 : 64'd2);
    cmp("R3 R10 mrs_req", 64'(mrs_req), 64'(ph == 1 || ph == 8));
    cmp("R3 R10 mrs_entry", 64'(mrs_entry), 64'(ph == 1));
    cmp("R3 R12 mrs_cs", 64'(cs), 64'(m_mod * 2));
    cmp("R4 R5 R10 odt", 64'(odt), 64'(ph >= 3 && ph <= 6));
    cmp("R5 seed_load", 64'(sload), 64'(ph == 4));
    if (ph == 4) cmp("R6 seed", seed, exp_seed);
    cmp("R7 train_en", 64'(train), 64'(ph == 5));
    cmp("R8 R9 wdqs", dly, exp_dly);
  end

  // companion mode-register responder
  always @(negedge clk) begin
    if (mrs_req) begin resp_cnt++; mrs_done <= (resp_cnt == MRS_LAT); end
    else begin resp_cnt = 0; mrs_done <= 1'b0; end
  end

  task automatic run(int m, int k, logic p2, logic [LANES-1:0] v,
                     logic [8*LANES-1:0] o, logic [8*LANES-1:0] r, bit poke);
    @(negedge clk);
    mod_sel = MOD_W'(m); kind = 2'(k); pass2 = p2; ovr_vld = v; ovr = o; res = r;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      // R12: start with other settings while busy
      mod_sel = ~mod_sel; kind = 2'd1; pass2 = ~p2; ovr_vld = '1; ovr = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp("R1 reset wdqs", dly, '0);
    cmp("R1 reset zq", 64'(zq), 64'd2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // unbuffered seed 0x1A: lanes with gross 3 -> 0 (R9)
    run(1, 0, 1'b0, '0, '0, 64'h7F_60_35_00_1F_74_E0_7A, 1'b0);
    cmp("R9 lane0 wrapped", 64'(dly[7:0]), 64'h00);
    cmp("R8 lane1 kept", 64'(dly[15:8]), 64'hE0);
    // registered seed 0x41: gross 3 result kept
    run(3, 1, 1'b1, '0, '0, 64'h11_22_33_44_55_66_77_78, 1'b0);
    cmp("R9 nonzero seed gross keeps", 64'(dly[7:0]), 64'h78);
    // small-outline with overrides
    run(2, 2, 1'b1, 8'b1010_0101, 64'h05_00_80_00_00_1C_00_E3,
        64'h65_70_62_71_7E_60_79_6A, 1'b0);
    // unbuffered via kind 3, busy poke
    run(0, 3, 1'b0, 8'b0001_0000, 64'h00_00_00_9F_00_00_00_00,
        64'h66_67_68_69_6A_6B_6C_6D, 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule